// File: doc/BRIEF.md
# Four-Way Operand Cache Lookup and Miss Controller

This block holds the tag, valid, dirty and recency state of a four-way, 256-set copy-back data cache with 32-byte lines. It decides hit or miss for each request and steers line replacement. The set is picked from the virtual address, so the lookup can start before translation finishes. The stored tag is compared against the translated physical address. Load and prefetch requests come in with the set index taken from virtual address bits [12:5] and with the physical line address. Each accepted request gets a registered response one cycle later that reports a hit, a miss or a bypass, together with a way number.

On a miss the controller picks a victim way. An invalid way is taken first, and otherwise the least recently used way. If the victim holds modified data, the controller first tells the data side to copy that line into a write-back buffer. It then starts the line fill over a start/done handshake. When the fill completes, it commits the new tag and makes the way most recent. Only after that does it release the buffered line to memory, over a second start/done handshake. While any of this is in progress, no new request is accepted. Clearing the cache-enable input turns every request into a bypass that leaves all cache state alone.

Top module: `occ_ctrl`

## Requirements
- R1: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. In the next cycle `rsp_valid` is 1 for exactly one cycle. `rsp_hit` is 1 when some valid way of set `req_vidx` holds a tag equal to `req_pline[23:5]`, which is physical address bits [28:10]. `rsp_way` then names that way.
- R2: A hit by a load (op 0), a prefetch (op 1) or a mark-dirty (op 2) makes the hit way the most recently used way of its set.
- R3: On a miss, the victim is the lowest-numbered invalid way of the set. If all ways are valid, the victim is the least recently used way. `rsp_way` reports the victim. After reset every way is invalid, and the recency order from oldest to newest is way 0, 1, 2, 3.
- R4: On a miss whose victim is clean or invalid, `fill_start` pulses in the cycle after acceptance. At that point `fill_set`, `fill_way` and `fill_line` name the set, the victim way and the requested line, and `wb_capture` stays 0. A hit starts no fill.
- R5: On a miss whose victim is valid and dirty, `wb_capture` pulses in the cycle after acceptance. At that point `wb_set`, `wb_way` and `wb_tag` name the victim. `fill_start` pulses in the following cycle.
- R6: A `fill_done` pulse during the fill writes the new tag into the victim way, sets its valid bit, clears its dirty bit and makes it most recently used. A later eviction of that way is therefore clean.
- R7: `wb_drain_start` pulses in the cycle after `fill_done`, and only for a miss that captured a dirty victim. It never occurs before the fill completes.
- R8: `req_ready` is 1 after reset. It is 0 from the cycle after a miss is accepted until the cycle after `fill_done` for a clean miss, or until the cycle after `wb_drain_done` for a dirty miss.
- R9: A request accepted with `cache_en` = 0 gives `rsp_bypass` = 1 and `rsp_hit` = 0. It starts no fill or capture, and it changes no tag, valid, dirty or recency state.
- R10: Op code 2 on a hit sets the dirty bit of the hit way. Op 3 acts as a load. Prefetch acts as a load for hit, miss and fill.
- R11: `req_pline[26:24]` (physical bits [31:29]) and `req_pline[4:0]` (physical bits [9:5]) play no part in the hit decision. A difference in `req_pline[23]` (physical bit 28) does make a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_en | input | 1 | Cache enable; 0 makes every request a bypass |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 2 | 0 load, 1 prefetch, 2 mark dirty, 3 load |
| req_vidx | input | 8 | Set index, virtual address bits [12:5] |
| req_pline | input | 27 | Physical line address, physical bits [31:5] |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Request hit |
| rsp_bypass | output | 1 | Request bypassed the cache |
| rsp_way | output | 2 | Hit way, or victim way on a miss |
| fill_start | output | 1 | One-cycle pulse starting a line fill |
| fill_set | output | 8 | Set being filled |
| fill_way | output | 2 | Way being filled |
| fill_line | output | 27 | Physical line address to fetch |
| fill_done | input | 1 | Fill unit finished the line |
| wb_capture | output | 1 | One-cycle pulse: copy victim line into the write-back buffer |
| wb_set | output | 8 | Victim set |
| wb_way | output | 2 | Victim way |
| wb_tag | output | 19 | Victim physical tag |
| wb_drain_start | output | 1 | One-cycle pulse: write buffered line to memory |
| wb_drain_done | input | 1 | Buffered line written |

## Verification
One set is filled through its invalid ways. Hits are then applied in orders chosen so that the least recently used way differs from the lowest-numbered way. This separates true recency tracking from a fixed or round-robin choice. A dirty-marked way is aged until it becomes the victim, which checks the capture, fill and drain order against the clean path. The same way is then refilled and evicted again, which shows that the fill cleared its dirty bit. Requests that vary only the physical bits outside the tag, or only bit 28, separate a correct tag slice from an off-by-some one. Bypassed requests to both resident and absent lines show that disabling the cache leaves the recency and valid state untouched.

// File: rtl/occ_pkg.sv
// Shared types for the operand cache controller.
// Assumes: request op codes are two bits wide; code 3 is treated as a load.
package occ_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_FILL_GO,
        ST_FILL_WAIT,
        ST_DRAIN_GO,
        ST_DRAIN_WAIT
    } occ_state_e;

    localparam logic [1:0] OP_LOAD       = 2'd0;
    localparam logic [1:0] OP_PREFETCH   = 2'd1;
    localparam logic [1:0] OP_MARK_DIRTY = 2'd2;

endpackage

// File: rtl/occ_tag_store.sv
// Tag, valid and dirty storage for every way of every set.
// Reads are combinational by set; one write port updates a single way.
// Assumes: a write always leaves the way valid; tags need no reset.
module occ_tag_store #(
    parameter int SETS  = 256,
    parameter int WAYS  = 4,
    parameter int TAG_W = 19
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(SETS)-1:0]       rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]    rd_tag,
    output logic [WAYS-1:0]               rd_valid,
    output logic [WAYS-1:0]               rd_dirty,
    input  logic                          wr_en,
    input  logic [$clog2(SETS)-1:0]       wr_set,
    input  logic [$clog2(WAYS)-1:0]       wr_way,
    input  logic [TAG_W-1:0]              wr_tag,
    input  logic                          wr_dirty
);

    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];

    // Present the addressed set to the lookup logic.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_tag[w] = tag_q[rd_set][w];
        end
        rd_valid = valid_q[rd_set];
        rd_dirty = dirty_q[rd_set];
    end

    // Tag payload write; no reset needed because valid gates every use.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way] <= wr_tag;
        end
    end

    // Valid and dirty bits: cleared by reset, updated by the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
            dirty_q[wr_set][wr_way] <= wr_dirty;
        end
    end

endmodule

// File: rtl/occ_lru.sv
// Recency tracking with one order bit per pair of ways in each set.
// For a pair (i, j) with i < j, a bit value of 1 means way i was used
// more recently than way j. Picks the victim: lowest invalid way first,
// otherwise the way that is older than every other way.
// Assumes: at most one touch per cycle; reset order is way 0 oldest.
module occ_lru #(
    parameter int SETS = 256,
    parameter int WAYS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] rd_set,
    input  logic [WAYS-1:0]         rd_valid,
    output logic [$clog2(WAYS)-1:0] victim_way,
    input  logic                    touch_en,
    input  logic [$clog2(SETS)-1:0] touch_set,
    input  logic [$clog2(WAYS)-1:0] touch_way
);

    localparam int WAY_W = $clog2(WAYS);
    localparam int PAIRS = WAYS * (WAYS - 1) / 2;

    logic [PAIRS-1:0] order_q [SETS];
    logic [PAIRS-1:0] cur_order;
    logic             vic_found;
    logic             way_old;

    // Flat bit position of pair (i, j), i < j.
    function automatic int pidx(input int i, input int j);
        return i * (2 * WAYS - i - 1) / 2 + (j - i - 1);
    endfunction

    // Victim choice: first invalid way, else the globally oldest way.
    always_comb begin
        cur_order  = order_q[rd_set];
        vic_found  = 1'b0;
        victim_way = '0;
        way_old    = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!vic_found && !rd_valid[w]) begin
                victim_way = WAY_W'(w);
                vic_found  = 1'b1;
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            way_old = 1'b1;
            for (int j = 0; j < WAYS; j++) begin
                if (j > w && cur_order[pidx(w, j)]) begin
                    way_old = 1'b0;
                end else if (j < w && !cur_order[pidx(j, w)]) begin
                    way_old = 1'b0;
                end
            end
            if (!vic_found && way_old) begin
                victim_way = WAY_W'(w);
                vic_found  = 1'b1;
            end
        end
    end

    // Order update: the touched way becomes newer than all others.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                order_q[s] <= '0;
            end
        end else if (touch_en) begin
            for (int j = 0; j < WAYS; j++) begin
                if (j < int'(touch_way)) begin
                    order_q[touch_set][pidx(j, int'(touch_way))] <= 1'b0;
                end else if (j > int'(touch_way)) begin
                    order_q[touch_set][pidx(int'(touch_way), j)] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/occ_miss_fsm.sv
// Sequencer for one outstanding miss: optional victim capture, fill
// start, fill wait, then an optional write-back drain.
// Assumes: fill_done and wb_drain_done are one-cycle pulses and are
// only meaningful in the matching wait state.
module occ_miss_fsm
    import occ_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic miss_go,
    input  logic miss_dirty,
    input  logic fill_done,
    input  logic wb_drain_done,
    output logic idle,
    output logic capture_pulse,
    output logic fill_pulse,
    output logic fill_commit,
    output logic drain_pulse
);

    occ_state_e state_q;
    logic       owe_drain_q;

    // Decode per-state outputs.
    always_comb begin
        idle          = (state_q == ST_IDLE);
        capture_pulse = (state_q == ST_CAPTURE);
        fill_pulse    = (state_q == ST_FILL_GO);
        fill_commit   = (state_q == ST_FILL_WAIT) && fill_done;
        drain_pulse   = (state_q == ST_DRAIN_GO);
    end

    // State progression and the drain-owed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            owe_drain_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (miss_go) begin
                        owe_drain_q <= miss_dirty;
                        state_q     <= miss_dirty ? ST_CAPTURE : ST_FILL_GO;
                    end
                end
                ST_CAPTURE:   state_q <= ST_FILL_GO;
                ST_FILL_GO:   state_q <= ST_FILL_WAIT;
                ST_FILL_WAIT: begin
                    if (fill_done) begin
                        state_q <= owe_drain_q ? ST_DRAIN_GO : ST_IDLE;
                    end
                end
                ST_DRAIN_GO:  state_q <= ST_DRAIN_WAIT;
                ST_DRAIN_WAIT: begin
                    if (wb_drain_done) begin
                        state_q     <= ST_IDLE;
                        owe_drain_q <= 1'b0;
                    end
                end
                default:      state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/occ_ctrl.sv
// Top of the operand cache controller: lookup, response, victim
// bookkeeping for the pending miss, and the update paths to tag and
// recency state.
// Assumes: the set index comes from the virtual address and the line
// address from translation; data movement is done by outside units.
module occ_ctrl
    import occ_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LINE_LSB = 5,
    parameter int SET_W    = 8,
    parameter int TAG_LSB  = 10,
    parameter int TAG_W    = 19,
    parameter int WAYS     = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cache_en,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [1:0]                   req_op,
    input  logic [SET_W-1:0]             req_vidx,
    input  logic [ADDR_W-LINE_LSB-1:0]   req_pline,
    output logic                         rsp_valid,
    output logic                         rsp_hit,
    output logic                         rsp_bypass,
    output logic [$clog2(WAYS)-1:0]      rsp_way,
    output logic                         fill_start,
    output logic [SET_W-1:0]             fill_set,
    output logic [$clog2(WAYS)-1:0]      fill_way,
    output logic [ADDR_W-LINE_LSB-1:0]   fill_line,
    input  logic                         fill_done,
    output logic                         wb_capture,
    output logic [SET_W-1:0]             wb_set,
    output logic [$clog2(WAYS)-1:0]      wb_way,
    output logic [TAG_W-1:0]             wb_tag,
    output logic                         wb_drain_start,
    input  logic                         wb_drain_done
);

    localparam int SETS    = 1 << SET_W;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int LINE_AW = ADDR_W - LINE_LSB;
    localparam int TAG_OFF = TAG_LSB - LINE_LSB;

    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [WAYS-1:0]            rd_valid;
    logic [WAYS-1:0]            rd_dirty;
    logic [WAYS-1:0]            match_vec;
    logic [TAG_W-1:0]           req_tag;
    logic                       any_match;
    logic [WAY_W-1:0]           match_way;
    logic [WAY_W-1:0]           victim_way;
    logic                       accept;
    logic                       lookup_hit;
    logic                       miss_go;
    logic                       victim_dirty;

    logic                       fsm_idle;
    logic                       fill_commit;

    logic [SET_W-1:0]           pend_set_q;
    logic [WAY_W-1:0]           pend_way_q;
    logic [LINE_AW-1:0]         pend_line_q;
    logic [TAG_W-1:0]           vic_tag_q;

    logic                       ts_wr_en;
    logic [SET_W-1:0]           ts_wr_set;
    logic [WAY_W-1:0]           ts_wr_way;
    logic [TAG_W-1:0]           ts_wr_tag;
    logic                       ts_wr_dirty;
    logic                       lru_touch;
    logic [SET_W-1:0]           lru_set;
    logic [WAY_W-1:0]           lru_way;

    occ_tag_store #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) tags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (req_vidx),
        .rd_tag   (rd_tag),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .wr_en    (ts_wr_en),
        .wr_set   (ts_wr_set),
        .wr_way   (ts_wr_way),
        .wr_tag   (ts_wr_tag),
        .wr_dirty (ts_wr_dirty)
    );

    occ_lru #(
        .SETS (SETS),
        .WAYS (WAYS)
    ) lru_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_set     (req_vidx),
        .rd_valid   (rd_valid),
        .victim_way (victim_way),
        .touch_en   (lru_touch),
        .touch_set  (lru_set),
        .touch_way  (lru_way)
    );

    occ_miss_fsm fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_go       (miss_go),
        .miss_dirty    (victim_dirty),
        .fill_done     (fill_done),
        .wb_drain_done (wb_drain_done),
        .idle          (fsm_idle),
        .capture_pulse (wb_capture),
        .fill_pulse    (fill_start),
        .fill_commit   (fill_commit),
        .drain_pulse   (wb_drain_start)
    );

    assign req_tag   = req_pline[TAG_OFF +: TAG_W];
    assign req_ready = fsm_idle;
    assign accept    = req_valid && req_ready;

    // Per-way tag comparison, one comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_vec[w] = rd_valid[w] && (rd_tag[w] == req_tag);
    end

    // Encode the matching way.
    always_comb begin
        match_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match_vec[w]) begin
                match_way = WAY_W'(w);
            end
        end
    end

    assign any_match    = |match_vec;
    assign lookup_hit   = cache_en && any_match;
    assign miss_go      = accept && cache_en && !any_match;
    assign victim_dirty = rd_valid[victim_way] && rd_dirty[victim_way];

    // Choose the single tag-store write: fill commit or dirty marking.
    always_comb begin
        ts_wr_en    = 1'b0;
        ts_wr_set   = req_vidx;
        ts_wr_way   = match_way;
        ts_wr_tag   = req_tag;
        ts_wr_dirty = 1'b1;
        if (fill_commit) begin
            ts_wr_en    = 1'b1;
            ts_wr_set   = pend_set_q;
            ts_wr_way   = pend_way_q;
            ts_wr_tag   = pend_line_q[TAG_OFF +: TAG_W];
            ts_wr_dirty = 1'b0;
        end else if (accept && lookup_hit && req_op == OP_MARK_DIRTY) begin
            ts_wr_en = 1'b1;
        end
    end

    // Choose the single recency touch: fill commit or hit.
    always_comb begin
        lru_touch = 1'b0;
        lru_set   = req_vidx;
        lru_way   = match_way;
        if (fill_commit) begin
            lru_touch = 1'b1;
            lru_set   = pend_set_q;
            lru_way   = pend_way_q;
        end else if (accept && lookup_hit) begin
            lru_touch = 1'b1;
        end
    end

    // Hold the pending miss: target way, new line and victim tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_set_q  <= '0;
            pend_way_q  <= '0;
            pend_line_q <= '0;
            vic_tag_q   <= '0;
        end else if (miss_go) begin
            pend_set_q  <= req_vidx;
            pend_way_q  <= victim_way;
            pend_line_q <= req_pline;
            vic_tag_q   <= rd_tag[victim_way];
        end
    end

    // Registered response, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_bypass <= 1'b0;
            rsp_way    <= '0;
        end else begin
            rsp_valid  <= accept;
            rsp_hit    <= accept && lookup_hit;
            rsp_bypass <= accept && !cache_en;
            rsp_way    <= !cache_en ? '0 : (any_match ? match_way : victim_way);
        end
    end

    assign fill_set  = pend_set_q;
    assign fill_way  = pend_way_q;
    assign fill_line = pend_line_q;
    assign wb_set    = pend_set_q;
    assign wb_way    = pend_way_q;
    assign wb_tag    = vic_tag_q;

endmodule

// File: rtl/occ_ctrl_chk.sv
// Protocol checker for occ_ctrl, attached by bind.
// Assumes: fill_done is a single-cycle pulse from the fill unit.
module occ_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cache_en,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic rsp_bypass,
    input logic fill_start,
    input logic fill_done,
    input logic wb_capture,
    input logic wb_drain_start
);

    AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid); // R1

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid); // R1

    AST_HIT_STARTS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (!fill_start && !wb_capture)); // R4

    AST_CAPTURE_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        wb_capture |=> fill_start); // R5

    AST_DRAIN_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        wb_drain_start |-> $past(fill_done)); // R7

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_start || wb_capture || wb_drain_start) |-> !req_ready); // R8

    AST_BYPASS_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cache_en) |=> (!fill_start && !wb_capture && rsp_bypass && !rsp_hit)); // R9

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fill_start, wb_capture, wb_drain_start})); // R8

endmodule

bind occ_ctrl occ_ctrl_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cache_en       (cache_en),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_bypass     (rsp_bypass),
    .fill_start     (fill_start),
    .fill_done      (fill_done),
    .wb_capture     (wb_capture),
    .wb_drain_start (wb_drain_start)
);

// File: tb/occ_ctrl_tb_top.sv
// Scoreboard bench: the driver predicts responses from its own cache
// model and queues them; a monitor pops and compares each response.
module occ_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [7:0]  req_vidx = 8'd0;
    logic [26:0] req_pline = 27'd0;
    logic        rsp_valid, rsp_hit, rsp_bypass;
    logic [1:0]  rsp_way;
    logic        fill_start;
    logic [7:0]  fill_set;
    logic [1:0]  fill_way;
    logic [26:0] fill_line;
    logic        fill_done = 1'b0;
    logic        wb_capture;
    logic [7:0]  wb_set;
    logic [1:0]  wb_way;
    logic [18:0] wb_tag;
    logic        wb_drain_start;
    logic        wb_drain_done = 1'b0;

    always #2.5 clk = ~clk;

    occ_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_vidx(req_vidx), .req_pline(req_pline),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_bypass(rsp_bypass),
        .rsp_way(rsp_way), .fill_start(fill_start), .fill_set(fill_set),
        .fill_way(fill_way), .fill_line(fill_line), .fill_done(fill_done),
        .wb_capture(wb_capture), .wb_set(wb_set), .wb_way(wb_way),
        .wb_tag(wb_tag), .wb_drain_start(wb_drain_start),
        .wb_drain_done(wb_drain_done)
    );

    typedef struct { logic hit; logic byp; logic [1:0] way; string req; } exp_t;
    exp_t exp_q[$];

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Bench model of the cache state.
    logic [18:0] m_tag [256][4];
    bit          m_v   [256][4];
    bit          m_u   [256][4];
    int          m_age [256][4];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic void touch(input int s, input int w);
        for (int k = 0; k < 4; k++) begin
            if (m_age[s][k] < m_age[s][w]) m_age[s][k]++;
        end
        m_age[s][w] = 0;
    endfunction

    // Monitor: compare every response with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R1 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.req, " hit"}, rsp_hit, e.hit);
                chk({e.req, " bypass"}, rsp_bypass, e.byp);
                if (!e.byp) chk({e.req, " way"}, rsp_way, e.way);
            end
        end
    end

    // Driver: one request plus, on a miss, the fill and drain handshakes.
    task automatic issue(input logic [1:0] op, input int s, input logic [18:0] tag,
                         input logic [2:0] hi, input logic [4:0] lo,
                         input logic en, input string req);
        exp_t e;
        int hw, vw;
        bit dirty;
        logic [18:0] vtag;
        logic [26:0] line;
        line = {hi, tag, lo};
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        hw = -1;
        for (int w = 0; w < 4; w++) if (m_v[s][w] && m_tag[s][w] == tag) hw = w;
        vw = -1;
        for (int w = 3; w >= 0; w--) if (!m_v[s][w]) vw = w;
        if (vw < 0) begin
            vw = 0;
            for (int w = 0; w < 4; w++) if (m_age[s][w] > m_age[s][vw]) vw = w;
        end
        dirty = m_v[s][vw] && m_u[s][vw];
        vtag  = m_tag[s][vw];
        e.req = req;
        e.byp = !en;
        e.hit = en && (hw >= 0);
        e.way = (hw >= 0) ? 2'(hw) : 2'(vw);
        exp_q.push_back(e);
        if (en && hw >= 0) begin
            touch(s, hw);
            if (op == 2'd2) m_u[s][hw] = 1;
        end
        cache_en = en; req_op = op; req_vidx = 8'(s); req_pline = line;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!en || hw >= 0) begin
            chk({req, " no fill after hit/bypass"}, {wb_capture, fill_start}, 0);
            chk({req, " ready stays"}, req_ready, 1);
        end else begin
            chk("R8 ready low on miss", req_ready, 0);
            if (dirty) begin
                chk("R5 capture pulse", wb_capture, 1);
                chk("R5 capture tag", wb_tag, vtag);
                chk("R5 capture way/set", {wb_way, wb_set}, {2'(vw), 8'(s)});
                chk("R5 no fill yet", fill_start, 0);
                @(negedge clk);
            end else begin
                chk("R4 no capture on clean victim", wb_capture, 0);
            end
            chk("R4 fill start", fill_start, 1);
            chk("R4 fill target", {fill_way, fill_set, fill_line}, {2'(vw), 8'(s), line});
            repeat (3) @(negedge clk);
            chk("R7 no drain before fill done", wb_drain_start, 0);
            chk("R8 ready low during fill", req_ready, 0);
            fill_done = 1'b1;
            @(negedge clk);
            fill_done = 1'b0;
            m_tag[s][vw] = tag; m_v[s][vw] = 1; m_u[s][vw] = 0;
            touch(s, vw);
            if (dirty) begin
                chk("R7 drain after fill", wb_drain_start, 1);
                chk("R8 ready low during drain", req_ready, 0);
                repeat (2) @(negedge clk);
                wb_drain_done = 1'b1;
                @(negedge clk);
                wb_drain_done = 1'b0;
                chk("R8 ready after drain", req_ready, 1);
            end else begin
                chk("R7 no drain for clean miss", wb_drain_start, 0);
                chk("R8 ready after fill", req_ready, 1);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        for (int s = 0; s < 256; s++) begin
            for (int w = 0; w < 4; w++) begin
                m_v[s][w] = 0; m_u[s][w] = 0; m_tag[s][w] = '0; m_age[s][w] = 3 - w;
            end
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset ready", req_ready, 1);
        chk("R1 reset no response", rsp_valid, 0);
        chk("R4 reset idle pulses", {fill_start, wb_capture, wb_drain_start}, 0);

        // R3: fill invalid ways in order; R1 hit; R10 prefetch acts as load.
        issue(2'd0, 5, 19'h00011, 3'd0, 5'd5, 1, "R3 first miss way0");
        issue(2'd0, 5, 19'h00011, 3'd0, 5'd5, 1, "R1 hit way0");
        issue(2'd1, 5, 19'h00022, 3'd0, 5'd5, 1, "R10 prefetch miss");
        issue(2'd0, 5, 19'h00033, 3'd0, 5'd5, 1, "R3 miss way2");
        issue(2'd3, 5, 19'h00044, 3'd0, 5'd5, 1, "R10 op3 miss way3");
        issue(2'd1, 5, 19'h00022, 3'd0, 5'd5, 1, "R10 prefetch hit");
        // R2: recency follows hits.
        issue(2'd0, 5, 19'h00011, 3'd0, 5'd5, 1, "R2 hit way0");
        issue(2'd0, 5, 19'h00055, 3'd0, 5'd5, 1, "R2 victim by recency");
        // R9: bypass on a resident and an absent line changes nothing.
        issue(2'd0, 5, 19'h00044, 3'd0, 5'd5, 0, "R9 bypass resident");
        issue(2'd2, 5, 19'h00099, 3'd0, 5'd5, 0, "R9 bypass absent");
        // R10: mark dirty, then age that way until it is the victim.
        issue(2'd2, 5, 19'h00044, 3'd0, 5'd5, 1, "R10 mark dirty hit");
        issue(2'd0, 5, 19'h00011, 3'd0, 5'd5, 1, "R2 age hit");
        issue(2'd0, 5, 19'h00055, 3'd0, 5'd5, 1, "R2 age hit");
        issue(2'd1, 5, 19'h00022, 3'd0, 5'd5, 1, "R2 age hit");
        issue(2'd0, 5, 19'h00066, 3'd0, 5'd5, 1, "R5 dirty victim");
        issue(2'd0, 5, 19'h00044, 3'd0, 5'd5, 1, "R6 evicted line misses");
        // R6: the refilled way must evict clean.
        issue(2'd0, 5, 19'h00044, 3'd0, 5'd5, 1, "R6 age hit");
        issue(2'd0, 5, 19'h00022, 3'd0, 5'd5, 1, "R6 age hit");
        issue(2'd0, 5, 19'h00055, 3'd0, 5'd5, 1, "R6 age hit");
        issue(2'd0, 5, 19'h00077, 3'd0, 5'd5, 1, "R6 clean re-eviction");
        // R11: bits outside the tag do not matter; bit 28 does.
        issue(2'd0, 5, 19'h00077, 3'd7, 5'd5, 1, "R11 upper bits ignored");
        issue(2'd0, 5, 19'h00077, 3'd0, 5'd30, 1, "R11 low line bits ignored");
        issue(2'd0, 5, 19'h40077, 3'd0, 5'd5, 1, "R11 bit 28 differs");
        // Other set is independent.
        issue(2'd0, 200, 19'h00011, 3'd0, 5'd8, 1, "R3 other set way0");
        issue(2'd0, 200, 19'h00011, 3'd0, 5'd8, 1, "R1 other set hit");

        repeat (4) @(negedge clk);
        chk("R1 all responses seen", exp_q.size(), 0);
        finish_run();
    end

endmodule